// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that finishes one instruction in every clock cycle. Fetch, decode, register read, the add/compare unit and the register write-back all happen between two rising edges. The program lives inside the core as a read-only byte array, fixed at elaboration through a parameter. Each instruction takes four consecutive bytes, and the most significant byte comes first.

Data memory is not part of the core. Loads and stores leave through a plain port: a byte address, a write-data word, a read-data word and a one-cycle write strobe. A RAM, a FIFO or a serial transmitter can sit behind it. The supported operations are register add, add-immediate, branch-if-equal, absolute jump, word load and word store. Every other encoding runs as a no-op.

Top module: `sc_rcore`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and clears every register. In the first cycle after reset is released, the core executes the instruction stored at bytes 0 to 3.
- R2: An instruction is the four bytes at PC, PC+1, PC+2 and PC+3, with the byte at PC as bits 31:24. The store holds 512 bytes, which is 128 instructions. The program counter always stays word aligned.
- R3: Add (opcode 0x00 with low six bits 0x20) writes rs+rt into rd. Add-immediate (opcode 0x08) writes rs plus the sign-extended bits 15:0 into rt. Both wrap modulo 2^32. The address port always shows the sum formed by the current instruction. For example, a repeated-addition loop computing 6 times 4 leaves 24 in r19.
- R4: Branch-if-equal (opcode 0x04) moves to PC+4+(sign-extended bits 15:0 times 4) when rs equals rt. Otherwise it moves to PC+4.
- R5: Jump (opcode 0x02) moves to {PC+4 bits 31:28, bits 25:0, 00}, with no base added. The word 0x08000004 moves to byte 16.
- R6: Register 0 always reads as zero, and writes to it leave no trace.
- R7: Store (opcode 0x2B) raises the write strobe for its own cycle only. In that cycle the address is rs plus the sign-extended bits 15:0, and the write data is rt. The strobe is low in every other cycle.
- R8: Load (opcode 0x23) drives the same address form with the strobe low. It writes the read-data input into rt at the end of that cycle.
- R9: Any other opcode, and opcode 0x00 with low bits other than 0x20, writes no register, raises no strobe and moves to PC+4.
- R10: A fetch at or beyond byte 512 returns an all-zero word, which executes as a no-op under R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Sum of the current instruction; byte address for load/store |
| mem_wdata | output | 32 | Store data (rt value) |
| mem_rdata | input | 32 | Load data from the external memory |
| mem_we | output | 1 | Store strobe, high for one cycle per store |

## Verification
The address, write data and strobe are combinational from the current instruction, so each one is due in the same cycle that instruction occupies. A register result becomes visible only through a later store, which is 1 to N cycles after the instruction that produced it. The bench runs a fixed program whose control flow is fully known. It therefore computes, for each cycle counted from reset release, which instruction is executing and what the port must show, and it samples one time unit after each falling edge so that every value has settled. The load data for the single load is directed or drawn from a seeded random source, and the stored result that follows is predicted from it.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef enum logic [5:0] {
      OP_REG   = 6'h00,
      OP_JUMP  = 6'h02,
      OP_BEQ   = 6'h04,
      OP_ADDI  = 6'h08,
      OP_LOAD  = 6'h23,
      OP_STORE = 6'h2B
   } opcode_e;

   localparam logic [5:0] FN_ADD = 6'h20;

   typedef struct packed {
      logic reg_we;
      logic dst_rd;
      logic use_imm;
      logic from_mem;
      logic mem_we;
      logic branch;
      logic jump;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   opcode_e op;
   assign op = opcode_e'(opcode);

   always_comb begin
      ctrl = '0;
      case (op)
         OP_REG: begin
            if (funct == FN_ADD) begin
               ctrl.reg_we = 1'b1;
               ctrl.dst_rd = 1'b1;
            end
         end
         OP_ADDI: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
         end
         OP_LOAD: begin
            ctrl.reg_we   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.from_mem = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_we  = 1'b1;
            ctrl.use_imm = 1'b1;
         end
         OP_BEQ:  ctrl.branch = 1'b1;
         OP_JUMP: ctrl.jump   = 1'b1;
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch #(
   parameter int unsigned              XLEN      = 32,
   parameter int unsigned              ROM_BYTES = 512,
   parameter logic [ROM_BYTES*8-1:0]   PROGRAM   = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take_branch,
   input  logic            jump,
   input  logic [XLEN-1:0] offset,
   output logic [XLEN-1:0] pc,
   output logic [31:0]     instr
);

   localparam int unsigned AW = $clog2(ROM_BYTES);

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_fetch: XLEN must be 32");
   end
   if (ROM_BYTES < 4 || (ROM_BYTES & (ROM_BYTES - 1)) != 0) begin : g_bad_rom
      $error("sc_fetch: ROM_BYTES must be a power of two of at least 4");
   end

   logic            in_range;
   logic [3:0][7:0] lanes;
   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] pc_next;

   assign in_range = (pc < XLEN'(ROM_BYTES));

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign lanes[3-l] = in_range
         ? PROGRAM[{pc[AW-1:0] + AW'(l), 3'b000} +: 8]
         : 8'h00;
   end

   assign instr    = lanes;
   assign pc_plus4 = pc + XLEN'(4);

   always_comb begin
      if (jump)
         pc_next = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
      else if (take_branch)
         pc_next = pc_plus4 + (offset << 2);
      else
         pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc_next;
   end

   assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);

   assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
      (!jump && !take_branch) |=> pc == $past(pc) + XLEN'(4));

   assert_jump_target_R5: assert property (@(posedge clk) disable iff (rst)
      jump |=> pc == {$past(pc_plus4[XLEN-1:28]), $past(instr[25:0]), 2'b00});

   assert_blank_fetch_R10: assert property (@(posedge clk) disable iff (rst)
      (pc >= XLEN'(ROM_BYTES)) |-> instr == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned NREG  = 32,
   localparam int unsigned RAW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [RAW-1:0]  ra_a,
   input  logic [RAW-1:0]  ra_b,
   input  logic            we,
   input  logic [RAW-1:0]  wa,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b
);

   if (NREG < 2) begin : g_bad_nreg
      $error("sc_regfile: NREG must be at least 2");
   end

   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we && wa != '0) begin
         regs[wa] <= wd;
      end
   end

   assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
   assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

   assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
      (ra_a == '0) |-> rd_a == '0);

   assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
      (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] sum,
   output logic            equal
);

   assign sum   = a + b;
   assign equal = (a == b);

endmodule

// File: rtl/sc_rcore.sv
module sc_rcore
   import sc_pkg::*;
#(
   parameter int unsigned            XLEN      = 32,
   parameter int unsigned            REG_COUNT = 32,
   parameter int unsigned            ROM_BYTES = 512,
   parameter logic [ROM_BYTES*8-1:0] PROGRAM   = '0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_we
);

   localparam int unsigned RAW = $clog2(REG_COUNT);

   if (REG_COUNT != 32) begin : g_bad_regs
      $error("sc_rcore: instruction fields address exactly 32 registers");
   end

   logic [XLEN-1:0] pc;
   logic [31:0]     instr;
   ctrl_t           ctrl;
   logic [XLEN-1:0] imm_sext;
   logic [XLEN-1:0] rs_val, rt_val;
   logic [XLEN-1:0] alu_b, sum, wr_data;
   logic            equal;
   logic [RAW-1:0]  wr_addr;

   assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

   sc_fetch #(
      .XLEN(XLEN), .ROM_BYTES(ROM_BYTES), .PROGRAM(PROGRAM)
   ) u_fetch (
      .clk(clk), .rst(rst),
      .take_branch(ctrl.branch & equal),
      .jump(ctrl.jump),
      .offset(imm_sext),
      .pc(pc),
      .instr(instr)
   );

   sc_decode u_decode (
      .opcode(instr[31:26]),
      .funct(instr[5:0]),
      .ctrl(ctrl)
   );

   assign wr_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
   assign wr_data = ctrl.from_mem ? mem_rdata : sum;

   sc_regfile #(
      .XLEN(XLEN), .NREG(REG_COUNT)
   ) u_regs (
      .clk(clk), .rst(rst),
      .ra_a(instr[25:21]), .ra_b(instr[20:16]),
      .we(ctrl.reg_we), .wa(wr_addr), .wd(wr_data),
      .rd_a(rs_val), .rd_b(rt_val)
   );

   assign alu_b = ctrl.use_imm ? imm_sext : rt_val;

   sc_alu #(.XLEN(XLEN)) u_alu (
      .a(rs_val), .b(alu_b), .sum(sum), .equal(equal)
   );

   assign mem_addr  = sum;
   assign mem_wdata = rt_val;
   assign mem_we    = ctrl.mem_we;

   assert_store_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> opcode_e'(instr[31:26]) == OP_STORE);

   assert_load_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (opcode_e'(instr[31:26]) == OP_LOAD) |-> !mem_we);

   assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == 6'h00 && instr[5:0] != 6'h20) |-> (!mem_we && !ctrl.reg_we));

endmodule

// File: tb/sim_sc_rcore.sv
`timescale 1ns/1ps
module sim_sc_rcore;

   localparam int ROM_B = 512;

   function automatic logic [ROM_B*8-1:0] place(input logic [ROM_B*8-1:0] p,
                                                input int idx, input logic [31:0] w);
      for (int k = 0; k < 4; k++) p[(idx*4+k)*8 +: 8] = w[31-8*k -: 8];
      return p;
   endfunction

   function automatic logic [ROM_B*8-1:0] build_prog();
      logic [ROM_B*8-1:0] p;
      p = '0;
      p = place(p,  0, 32'h20110006); // r17 = 6
      p = place(p,  1, 32'h20120004); // r18 = 4
      p = place(p,  2, 32'h20100000); // r16 = 0
      p = place(p,  3, 32'h20130000); // r19 = 0
      p = place(p,  4, 32'h12110003); // loop: beq r16,r17 -> word 8
      p = place(p,  5, 32'h02729820); // r19 += r18
      p = place(p,  6, 32'h22100001); // r16 += 1
      p = place(p,  7, 32'h08000004); // jump to byte 16
      p = place(p,  8, 32'hAC130040); // store r19 -> 0x40
      p = place(p,  9, 32'h20000005); // write to r0
      p = place(p, 10, 32'hAC000044); // store r0 -> 0x44
      p = place(p, 11, 32'h8C140080); // load r20 <- [0x80]
      p = place(p, 12, 32'h2295FFFE); // r21 = r20 - 2
      p = place(p, 13, 32'hAE75FFFC); // store r21 -> r19-4
      p = place(p, 14, 32'hFFFFFFFF); // unknown opcode
      p = place(p, 15, 32'h02729822); // unknown funct
      p = place(p, 16, 32'h12600005); // beq not taken
      p = place(p, 17, 32'hAC130048); // store r19 -> 0x48
      p = place(p, 18, 32'hAC1F004C); // store r31 -> 0x4C
      p = place(p, 19, 32'h10000001); // beq taken, skip word 20
      p = place(p, 20, 32'hAC000050); // must not run
      p = place(p, 21, 32'h08000040); // jump to byte 256
      p = place(p, 64, 32'hAC110054); // store r17 -> 0x54
      p = place(p, 65, 32'h08000080); // jump to byte 512 (outside store)
      return p;
   endfunction

   localparam logic [ROM_B*8-1:0] PROG = build_prog();

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_we;

   always #2 clk = ~clk;

   sc_rcore #(.ROM_BYTES(ROM_B), .PROGRAM(PROG)) u0 (
      .clk(clk), .rst(rst),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_we(mem_we)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic store_chk(input string tag, input logic [31:0] a, input logic [31:0] d);
      check(mem_we == 1'b1, tag, "strobe", {31'd0, mem_we}, 32'd1);
      check(mem_addr == a, tag, "store address", mem_addr, a);
      check(mem_wdata == d, tag, "store data", mem_wdata, d);
   endtask

   function automatic string idle_tag(input int c);
      if (c < 29 || c == 40 || c == 41) return "R4";
      if (c >= 44) return "R10";
      return "R7";
   endfunction

   task automatic run_prog(input logic [31:0] v);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 check(mem_we == 1'b0, "R1", "strobe in reset", {31'd0, mem_we}, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      for (int c = 0; c < 300; c++) begin
         mem_rdata = (c == 32) ? v : $urandom;
         #1;
         case (c)
            0:  check(mem_addr == 32'd6, "R1", "first sum", mem_addr, 32'd6);
            1:  check(mem_addr == 32'd4, "R2", "second sum", mem_addr, 32'd4);
            29: store_chk("R3", 32'h40, 32'd24);
            31: store_chk("R6", 32'h44, 32'd0);
            32: begin
               check(mem_we == 1'b0, "R8", "load strobe", {31'd0, mem_we}, 32'd0);
               check(mem_addr == 32'h80, "R8", "load address", mem_addr, 32'h80);
            end
            34: store_chk("R8", 32'd20, v - 32'd2);
            38: store_chk("R9", 32'h48, 32'd24);
            39: store_chk("R9", 32'h4C, 32'd0);
            42: store_chk("R5", 32'h54, 32'd6);
            default: check(mem_we == 1'b0, idle_tag(c), "idle strobe",
                           {31'd0, mem_we}, 32'd0);
         endcase
         @(negedge clk);
      end
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED);
      run_prog(32'h0000_0000);
      run_prog(32'h0000_0001);
      run_prog(32'h8000_0001);
      for (int r = 0; r < 5; r++) run_prog($urandom);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule